// File: doc/BRIEF.md
# Terminal Output Formatter

This block sits at the receive end of a framed line and hands recovered bits to the terminal side. Each incoming bit arrives with a valid qualifier and a set of tags: one marks alignment-pattern positions, one marks housekeeping (service) positions, one marks positions of the parity nibble, and a frame-start flag marks the first bit of every frame. The block never works out for itself which positions are overhead. It trusts the tags.

Two output personalities are offered. In bit-serial mode every received bit is passed on with a per-bit enable, and a gap indicator flags alignment and service positions. In nibble mode only payload bits are kept. They are packed most-significant-first into a parallel word of `NIB_W` bits, which is announced by a one-cycle strobe. The strobe never fires for overhead positions. In both modes a frame pulse accompanies the first output unit of each frame.

The mode comes either from a pin or from a register bit, and a selector input picks between the two. A new mode is adopted only on a bit that carries the frame-start tag, so a frame is never split between the two formats. Every output is registered and lags its input bit by one clock.

Top module: `termfmt_out`

## Requirements
- R1: While `rst` is high and on the first cycle after it, all outputs are 0 and the active mode is serial (`mode_nib` = 0).
- R2: The requested mode is `mode_reg` when `mode_use_reg` = 1 and `mode_pin` otherwise, where 1 means nibble and 0 means serial. `mode_nib` shows the active mode one clock after it is adopted.
- R3: The active mode changes only on a valid bit whose `in_fstart` = 1. That bit and every later bit of the frame are formatted in the new mode. A change on the select inputs in mid-frame has no effect until then.
- R4: In serial mode each valid input bit produces `ser_en` = 1 with `ser_data` equal to that bit on the following clock. `ser_en` is 0 on cycles that follow a cycle with no valid input.
- R5: In serial mode `ser_gap` is 1 exactly for bits tagged as alignment (`in_fas`) or service (`in_svc`). Bits tagged parity-only are passed as ungapped bits.
- R6: In serial mode `ser_fp` is 1 together with the output of the bit that carried `in_fstart`, and is 0 for every other bit.
- R7: In nibble mode payload bits are shifted in. The first of every four lands in `nib_data[3]` and the last in `nib_data[0]`. `nib_stb` pulses for one clock, on the clock after the fourth payload bit.
- R8: In nibble mode a bit tagged with any of `in_fas`, `in_svc` or `in_par` is dropped. It does not count toward a nibble and produces no strobe.
- R9: In nibble mode `nib_fp` is 1 with the first `nib_stb` after a frame start and 0 for every other strobe.
- R10: A frame start discards any partially collected nibble. The bit that carries it, if it is payload, becomes the first bit of a new nibble.
- R11: The outputs of the inactive mode stay 0: `ser_en`, `ser_data`, `ser_gap` and `ser_fp` in nibble mode, and `nib_stb`, `nib_data` and `nib_fp` in serial mode. `nib_stb` and `ser_en` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input bit present this cycle |
| in_bit | input | 1 | Received bit |
| in_fas | input | 1 | Bit is in an alignment-pattern position |
| in_svc | input | 1 | Bit is in a service-bit position |
| in_par | input | 1 | Bit is in the parity-nibble position |
| in_fstart | input | 1 | Bit is the first bit of a frame |
| mode_pin | input | 1 | Mode request from pin (1 = nibble) |
| mode_reg | input | 1 | Mode request from register bit (1 = nibble) |
| mode_use_reg | input | 1 | 1 selects `mode_reg`, 0 selects `mode_pin` |
| ser_data | output | 1 | Serial data bit |
| ser_en | output | 1 | Serial per-bit clock enable |
| ser_gap | output | 1 | Serial gap indicator for alignment and service bits |
| ser_fp | output | 1 | Serial frame pulse |
| nib_data | output | NIB_W | Parallel payload word, first bit in MSB |
| nib_stb | output | 1 | Gapped nibble strobe |
| nib_fp | output | 1 | Nibble frame pulse |
| mode_nib | output | 1 | Active mode (1 = nibble) |

## Verification
The hardest cases to reach are a frame start that arrives while a nibble is only partly collected, and a mode request that changes in mid-frame. In both, the visible effect is delayed or hidden. The stimulus sends payload bits that stop short of a full nibble and then opens a new frame whose first bits complete a word, so any bit carried over from the old frame would corrupt the value or the frame-pulse position. It also toggles the pin and the register select between frame starts and keeps sending bits, so that a premature switch would show up as a strobe from the wrong output group.

// File: rtl/termfmt_pkg.sv
package termfmt_pkg;

  typedef enum logic {
    MODE_SER = 1'b0,
    MODE_NIB = 1'b1
  } out_mode_t;

  typedef struct packed {
    logic fas;
    logic svc;
    logic par;
    logic fstart;
  } bit_tag_t;

  // gapped in serial mode: alignment and service positions only
  function automatic logic tag_gapped(input bit_tag_t t);
    return t.fas | t.svc;
  endfunction

  // removed in nibble mode: every overhead position
  function automatic logic tag_overhead(input bit_tag_t t);
    return t.fas | t.svc | t.par;
  endfunction

endpackage

// File: rtl/termfmt_mode_ctl.sv
module termfmt_mode_ctl
  import termfmt_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      in_valid,
  input  logic      in_fstart,
  input  logic      mode_pin,
  input  logic      mode_reg,
  input  logic      mode_use_reg,
  output out_mode_t mode_eff,
  output out_mode_t mode_q
);

  logic      frame_edge;
  out_mode_t mode_req;

  assign frame_edge = in_valid & in_fstart;
  assign mode_req   = out_mode_t'(mode_use_reg ? mode_reg : mode_pin);

  // the bit carrying the frame start is already handled in the new mode
  assign mode_eff = frame_edge ? mode_req : mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_SER;
    end else if (frame_edge) begin
      mode_q <= mode_req;
    end
  end

  // R3
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_edge |=> $stable(mode_q));

endmodule

// File: rtl/termfmt_ser_path.sv
module termfmt_ser_path
  import termfmt_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     en,
  input  logic     in_bit,
  input  bit_tag_t tag,
  output logic     ser_data,
  output logic     ser_en,
  output logic     ser_gap,
  output logic     ser_fp
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ser_data <= 1'b0;
      ser_en   <= 1'b0;
      ser_gap  <= 1'b0;
      ser_fp   <= 1'b0;
    end else begin
      ser_en   <= en;
      ser_data <= en & in_bit;
      ser_gap  <= en & tag_gapped(tag);
      ser_fp   <= en & tag.fstart;
    end
  end

  // R5
  gap_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    ser_gap |-> ser_en);

  // R6
  fp_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    ser_fp |-> ser_en);

endmodule

// File: rtl/termfmt_nib_path.sv
module termfmt_nib_path
  import termfmt_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             flush,
  input  logic             in_bit,
  input  bit_tag_t         tag,
  output logic [NIB_W-1:0] nib_data,
  output logic             nib_stb,
  output logic             nib_fp
);

  localparam int CW = (NIB_W > 2) ? $clog2(NIB_W) : 1;
  localparam logic [CW-1:0] LAST = CW'(NIB_W - 1);

  logic [NIB_W-2:0] acc;
  logic [CW-1:0]    cnt;
  logic             pend;
  logic             take;
  logic [CW-1:0]    cnt_base;
  logic             pend_base;
  logic [NIB_W-1:0] word;

  assign take      = en & ~tag_overhead(tag);
  assign cnt_base  = flush ? '0 : cnt;
  assign pend_base = flush | pend;
  assign word      = {acc, in_bit};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc      <= '0;
      cnt      <= '0;
      pend     <= 1'b0;
      nib_data <= '0;
      nib_stb  <= 1'b0;
      nib_fp   <= 1'b0;
    end else begin
      nib_data <= '0;
      nib_stb  <= 1'b0;
      nib_fp   <= 1'b0;
      cnt      <= cnt_base;
      pend     <= pend_base;
      if (take) begin
        acc <= word[NIB_W-2:0];
        if (cnt_base == LAST) begin
          nib_data <= word;
          nib_stb  <= 1'b1;
          nib_fp   <= pend_base;
          cnt      <= '0;
          pend     <= 1'b0;
        end else begin
          cnt <= CW'(cnt_base + 1'b1);
        end
      end
    end
  end

  // R9
  fp_on_stb_chk: assert property (@(posedge clk) disable iff (rst)
    nib_fp |-> nib_stb);

  // R7
  stb_single_chk: assert property (@(posedge clk) disable iff (rst)
    nib_stb |=> !nib_stb);

  // R10
  flush_no_stb_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> !nib_stb);

endmodule

// File: rtl/termfmt_out.sv
module termfmt_out
  import termfmt_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_bit,
  input  logic             in_fas,
  input  logic             in_svc,
  input  logic             in_par,
  input  logic             in_fstart,
  input  logic             mode_pin,
  input  logic             mode_reg,
  input  logic             mode_use_reg,
  output logic             ser_data,
  output logic             ser_en,
  output logic             ser_gap,
  output logic             ser_fp,
  output logic [NIB_W-1:0] nib_data,
  output logic             nib_stb,
  output logic             nib_fp,
  output logic             mode_nib
);

  bit_tag_t  tag;
  out_mode_t mode_eff;
  out_mode_t mode_q;
  logic      ser_go;
  logic      nib_go;
  logic      flush;

  assign tag    = '{fas: in_fas, svc: in_svc, par: in_par, fstart: in_fstart};
  assign ser_go = in_valid & (mode_eff == MODE_SER);
  assign nib_go = in_valid & (mode_eff == MODE_NIB);
  assign flush  = in_valid & in_fstart;
  assign mode_nib = (mode_q == MODE_NIB);

  termfmt_mode_ctl i_mode (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_fstart    (in_fstart),
    .mode_pin     (mode_pin),
    .mode_reg     (mode_reg),
    .mode_use_reg (mode_use_reg),
    .mode_eff     (mode_eff),
    .mode_q       (mode_q)
  );

  termfmt_ser_path i_ser (
    .clk      (clk),
    .rst      (rst),
    .en       (ser_go),
    .in_bit   (in_bit),
    .tag      (tag),
    .ser_data (ser_data),
    .ser_en   (ser_en),
    .ser_gap  (ser_gap),
    .ser_fp   (ser_fp)
  );

  termfmt_nib_path #(.NIB_W(NIB_W)) i_nib (
    .clk      (clk),
    .rst      (rst),
    .en       (nib_go),
    .flush    (flush),
    .in_bit   (in_bit),
    .tag      (tag),
    .nib_data (nib_data),
    .nib_stb  (nib_stb),
    .nib_fp   (nib_fp)
  );

  // R11
  groups_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(ser_en && nib_stb));

  // R11
  ser_idle_in_nib_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_NIB) && !flush |=> !ser_en);

endmodule

// File: tb/test_termfmt_out.sv
module test_termfmt_out;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_bit = 1'b0, in_fas = 1'b0, in_svc = 1'b0;
  logic in_par = 1'b0, in_fstart = 1'b0;
  logic mode_pin = 1'b0, mode_reg = 1'b0, mode_use_reg = 1'b0;
  logic ser_data, ser_en, ser_gap, ser_fp, nib_stb, nib_fp, mode_nib;
  logic [3:0] nib_data;

  always #4 clk = ~clk;

  termfmt_out #(.NIB_W(4)) i_termfmt_out (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_bit(in_bit),
    .in_fas(in_fas), .in_svc(in_svc), .in_par(in_par), .in_fstart(in_fstart),
    .mode_pin(mode_pin), .mode_reg(mode_reg), .mode_use_reg(mode_use_reg),
    .ser_data(ser_data), .ser_en(ser_en), .ser_gap(ser_gap), .ser_fp(ser_fp),
    .nib_data(nib_data), .nib_stb(nib_stb), .nib_fp(nib_fp), .mode_nib(mode_nib)
  );

  typedef struct packed {
    logic       kind;   // 1 = nibble strobe, 0 = serial bit
    logic [3:0] d;
    logic       fp;
    logic       gap;
  } item_t;

  item_t q[$];
  int checks = 0;
  int fails  = 0;

  // reference state kept from the requirements
  logic       m_mode = 1'b0;
  logic [3:0] m_acc = 4'h0;
  int         m_cnt = 0;
  logic       m_pend = 1'b0;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic b, input logic fas, input logic svc,
                       input logic par, input logic fs);
    @(negedge clk);
    in_valid = 1'b1; in_bit = b; in_fas = fas; in_svc = svc;
    in_par = par; in_fstart = fs;
    if (fs) begin
      m_mode = mode_use_reg ? mode_reg : mode_pin;   // R2 R3
      m_pend = 1'b1;
      m_cnt  = 0;                                    // R10
    end
    if (!m_mode) begin
      q.push_back('{kind: 1'b0, d: {3'b000, b}, fp: fs, gap: fas | svc});
    end else if (!(fas | svc | par)) begin           // R8
      m_acc = {m_acc[2:0], b};
      m_cnt++;
      if (m_cnt == 4) begin                          // R7 R9
        q.push_back('{kind: 1'b1, d: m_acc, fp: m_pend, gap: 1'b0});
        m_pend = 1'b0;
        m_cnt  = 0;
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; in_bit = 1'b0; in_fas = 1'b0; in_svc = 1'b0;
      in_par = 1'b0; in_fstart = 1'b0;
    end
  endtask

  task automatic drain(input string req);
    idle(3);
    chk(q.size() == 0, req, q.size(), 0);
  endtask

  // monitor: pops one expected item for every strobe seen on the outputs
  always @(negedge clk) begin
    if (!rst) begin
      if (ser_en && nib_stb) begin
        chk(1'b0, "R11 both groups active", 3, 1);
      end else if (ser_en || nib_stb) begin
        item_t got, exp;
        got.kind = nib_stb;
        got.d    = nib_stb ? nib_data : {3'b000, ser_data};
        got.fp   = nib_stb ? nib_fp : ser_fp;
        got.gap  = ser_gap;
        if (q.size() == 0) begin
          chk(1'b0, "R3 R8 R11 unexpected strobe", int'(got), 0);
        end else begin
          exp = q.pop_front();
          chk(got == exp, exp.kind ? "R7 R8 R9 R10 R11 nibble" : "R4 R5 R6 R11 serial",
              int'(got), int'(exp));
        end
      end else begin
        // R4 R11: quiet outputs between strobes
        chk({ser_data, ser_gap, ser_fp, nib_fp, nib_data} == 8'h00,
            "R4 R11 idle outputs", {ser_data, ser_gap, ser_fp, nib_fp, nib_data}, 0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [9:0] align;
    align = 10'b1111010000;
    repeat (3) @(negedge clk);
    // R1
    chk({ser_data, ser_en, ser_gap, ser_fp, nib_data, nib_stb, nib_fp, mode_nib} == 12'h000,
        "R1 outputs in reset",
        {ser_data, ser_en, ser_gap, ser_fp, nib_data, nib_stb, nib_fp, mode_nib}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(mode_nib == 1'b0, "R1 mode after reset", mode_nib, 0);

    // serial frame: alignment, service, payload, parity, with idle gaps
    for (int i = 9; i >= 0; i--) drive(align[i], 1'b1, 1'b0, 1'b0, i == 9);
    drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    idle(2);
    for (int i = 7; i >= 0; i--) drive(8'hA5 >> i, 1'b0, 1'b0, 1'b0, 1'b0);
    for (int i = 3; i >= 0; i--) drive(4'b0110 >> i, 1'b0, 1'b0, 1'b1, 1'b0);
    drain("R4 R5 R6 serial frame drained");

    // R3: request nibble mid-frame, nothing changes until a frame start
    mode_pin = 1'b1;
    for (int i = 0; i < 6; i++) drive(i[0], 1'b0, 1'b0, 1'b0, 1'b0);
    idle(1);
    chk(mode_nib == 1'b0, "R3 mode held mid-frame", mode_nib, 0);
    drain("R3 serial kept mid-frame");

    // R2: frame start adopts nibble from pin
    drive(align[9], 1'b1, 1'b0, 1'b0, 1'b1);
    idle(1);
    chk(mode_nib == 1'b1, "R2 pin selects nibble", mode_nib, 1);
    for (int i = 8; i >= 0; i--) drive(align[i], 1'b1, 1'b0, 1'b0, 1'b0);
    drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    // R7 R8: payload 0xC3E with overhead interleaved
    for (int i = 11; i >= 6; i--) drive(12'hC3E >> i, 1'b0, 1'b0, 1'b0, 1'b0);
    drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    idle(1);
    for (int i = 5; i >= 0; i--) drive(12'hC3E >> i, 1'b0, 1'b0, 1'b0, 1'b0);
    // R10: leave three payload bits pending
    for (int i = 0; i < 3; i++) drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    drain("R7 R8 R9 nibble frame drained");

    // R10: new frame whose first bit is payload; 0x5B expected, first with fp
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    for (int i = 6; i >= 0; i--) drive(8'h5B >> i, 1'b0, 1'b0, 1'b0, 1'b0);
    drain("R10 partial nibble discarded");

    // R2: register source selects serial although pin asks nibble
    mode_use_reg = 1'b1; mode_reg = 1'b0;
    drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    idle(1);
    chk(mode_nib == 1'b0, "R2 register selects serial", mode_nib, 0);
    for (int i = 0; i < 4; i++) drive(i[1], 1'b0, 1'b0, 1'b0, 1'b0);
    drain("R2 serial from register");

    // R2: register selects nibble while pin asks serial
    mode_pin = 1'b0; mode_reg = 1'b1;
    drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    idle(1);
    chk(mode_nib == 1'b1, "R2 register selects nibble", mode_nib, 1);
    for (int i = 0; i < 7; i++) drive(i[0], 1'b0, 1'b0, 1'b0, 1'b0);
    drain("R9 second frame nibble");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule